// File: doc/BRIEF.md
# Two-Slot Transmit Handoff Controller

This block arbitrates a two-slot transmit staging area that sits between a producer, which writes outgoing packets, and a consumer, which reads them out. The block keeps two wrapping packet counters. The input count advances each time the producer commits a packet. The output count advances each time the consumer releases a slot. The number of occupied slots is the difference between the two counts, modulo the counter range. From that difference the block tells the producer whether a slot is free and tells the consumer whether a packet is waiting.

The slot that the producer fills next is given by the low bit of the input count. The slot that the consumer drains next is given by the low bit of the output count. Successive packets therefore alternate between the two slots. Every accepted commit raises a one-cycle doorbell toward the consumer. The output count is also visible to the producer through a status word, so a polling producer can see the consumer's progress. A strobe that arrives when it cannot be honoured is dropped, and it sets a sticky error flag.

Top module: `txslot_handoff`

## Requirements
- R1: After reset, both counts are 0, `slot_free_o` is 1, `pkt_ready_o` is 0, both slot indices are 0, and `doorbell_o`, `ovf_err_o` and `unf_err_o` are all 0.
- R2: `slot_free_o` is 1 exactly when (input count − output count) mod 16 is less than 2. `pkt_ready_o` is 1 exactly when that difference is not 0.
- R3: A commit sampled while `slot_free_o` is 1 raises the input count by 1 at that clock edge.
- R4: A commit sampled while `slot_free_o` is 0 leaves the input count unchanged and raises no doorbell. It sets `ovf_err_o`, which then stays 1 until reset.
- R5: `doorbell_o` is 1 for the one cycle that follows each accepted commit, and is 0 in every other cycle.
- R6: `wr_slot_o` equals bit 0 of the input count, so it toggles on each accepted commit. `rd_slot_o` equals bit 0 of the output count.
- R7: A release sampled while `pkt_ready_o` is 1 raises the output count by 1.
- R8: A release sampled while `pkt_ready_o` is 0 leaves the output count unchanged. It sets `unf_err_o`, which then stays 1 until reset.
- R9: `status_o[3:0]` carries the output count, and `status_o[7:4]` is 0.
- R10: A commit and a release in the same cycle are each judged on the occupancy before that edge. With one slot occupied, both take effect. With two slots occupied, the release takes effect and the commit is rejected.
- R11: Both counts wrap from 15 to 0, and occupancy and slot indices stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | Producer has written a packet into `wr_slot_o` |
| release_i | input | 1 | Consumer has finished reading `rd_slot_o` |
| status_o | output | 8 | Status word; the output count is in bits 3:0 |
| in_count_o | output | 4 | Input packet count |
| slot_free_o | output | 1 | A commit would be accepted this cycle |
| pkt_ready_o | output | 1 | At least one slot holds a packet |
| wr_slot_o | output | 1 | Slot the next commit lands in |
| rd_slot_o | output | 1 | Slot the consumer reads next |
| doorbell_o | output | 1 | One-cycle notification after an accepted commit |
| ovf_err_o | output | 1 | Sticky flag: a commit arrived while both slots were full |
| unf_err_o | output | 1 | Sticky flag: a release arrived with no slot occupied |

## Verification
The assertions check four behaviours on every cycle:
- the occupancy never exceeds two;
- each counter only ever steps by one, and only on a strobe;
- a rejected commit or release leaves its counter untouched, and the two error flags never clear;
- each doorbell coincides with a one-step rise of the input count and a toggle of the write slot.

Only the bench scenarios can show the rest: the exact reset values, the outcome of simultaneous commit and release at occupancy one and at occupancy two, the status word layout, and correct slot alternation across a full counter wrap.

// File: rtl/txslot_pkg.sv
package txslot_pkg;

  // Outcome of one strobe at a clock edge
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,
    EV_ACCEPT = 2'd1,
    EV_REJECT = 2'd2
  } txslot_ev_e;

  function automatic txslot_ev_e classify(input logic strobe, input logic allowed);
    if (!strobe)      return EV_IDLE;
    else if (allowed) return EV_ACCEPT;
    else              return EV_REJECT;
  endfunction

endpackage

// File: rtl/txslot_counter.sv
module txslot_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  // Advance by one on each accepted strobe; the natural overflow gives the wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (inc_i) count_q <= count_q + ONE;
  end

  assign count_o = count_q;

  // R11: a counter changes only by a single step (mod 2^CNT_W), and only after a strobe
  p_count_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> ($past(inc_i) && count_o == $past(count_o) + ONE));

endmodule

// File: rtl/txslot_gate.sv
module txslot_gate
  import txslot_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             release_i,
  input  logic [CNT_W-1:0] in_cnt_i,
  input  logic [CNT_W-1:0] out_cnt_i,
  output logic             commit_ok_o,
  output logic             release_ok_o,
  output logic             space_o,
  output logic             ready_o,
  output logic             ovf_err_o,
  output logic             unf_err_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // Occupied slots: distance between the two wrapping counts
  function automatic logic [CNT_W-1:0] occupancy(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
    return a - b;
  endfunction

  logic [CNT_W-1:0] occ;
  txslot_ev_e       commit_ev, release_ev;
  logic             ovf_q, unf_q;

  assign occ     = occupancy(in_cnt_i, out_cnt_i);
  assign space_o = (occ < DEPTH_C);
  assign ready_o = (occ != '0);

  // Both strobes are judged on the occupancy before the edge
  assign commit_ev    = classify(commit_i, space_o);
  assign release_ev   = classify(release_i, ready_o);
  assign commit_ok_o  = (commit_ev == EV_ACCEPT);
  assign release_ok_o = (release_ev == EV_ACCEPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (commit_ev == EV_REJECT)  ovf_q <= 1'b1;
      if (release_ev == EV_REJECT) unf_q <= 1'b1;
    end
  end

  assign ovf_err_o = ovf_q;
  assign unf_err_o = unf_q;

  // R2: the counters can never drift further apart than the slot count
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_C);

  // R4: the overflow flag never clears once set
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err_o |=> ovf_err_o);

  // R8: the underflow flag never clears once set
  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err_o |=> unf_err_o);

endmodule

// File: rtl/txslot_bell.sv
module txslot_bell (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic bell_o
);
  logic bell_q;

  // One registered pulse per accepted commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bell_q <= 1'b0;
    else        bell_q <= fire_i;
  end

  assign bell_o = bell_q;

endmodule

// File: rtl/txslot_handoff.sv
module txslot_handoff #(
  parameter int CNT_W  = 4,
  parameter int DEPTH  = 2,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              release_i,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  in_count_o,
  output logic              slot_free_o,
  output logic              pkt_ready_o,
  output logic              wr_slot_o,
  output logic              rd_slot_o,
  output logic              doorbell_o,
  output logic              ovf_err_o,
  output logic              unf_err_o
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Internal events, named so the assertions can see them
  logic             commit_ok, release_ok;
  logic [CNT_W-1:0] in_cnt, out_cnt;
  logic [SLOT_W-1:0] wr_idx, rd_idx;

  txslot_gate #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (commit_i),
    .release_i    (release_i),
    .in_cnt_i     (in_cnt),
    .out_cnt_i    (out_cnt),
    .commit_ok_o  (commit_ok),
    .release_ok_o (release_ok),
    .space_o      (slot_free_o),
    .ready_o      (pkt_ready_o),
    .ovf_err_o    (ovf_err_o),
    .unf_err_o    (unf_err_o)
  );

  txslot_counter #(.CNT_W(CNT_W)) u_in_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (commit_ok),
    .count_o (in_cnt)
  );

  txslot_counter #(.CNT_W(CNT_W)) u_out_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (release_ok),
    .count_o (out_cnt)
  );

  txslot_bell u_bell (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (commit_ok),
    .bell_o (doorbell_o)
  );

  // Slot index is the count modulo the (power-of-two) slot count
  assign wr_idx = in_cnt[SLOT_W-1:0];
  assign rd_idx = out_cnt[SLOT_W-1:0];

  assign wr_slot_o  = wr_idx[0];
  assign rd_slot_o  = rd_idx[0];
  assign in_count_o = in_cnt;
  assign status_o   = STAT_W'(out_cnt);

  // R4: a commit with no free slot leaves the input count untouched
  p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !slot_free_o) |=> (in_count_o == $past(in_count_o)));

  // R8: a release with nothing stored leaves the output count untouched and flags it
  p_empty_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !pkt_ready_o) |=> (status_o == $past(status_o) && unf_err_o));

  // R5: a doorbell cycle is always the cycle in which the input count has just stepped
  p_bell_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_o |-> (in_count_o == $past(in_count_o) + ONE));

  // R6: each doorbell coincides with a change of write slot
  p_wr_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_o |-> (wr_slot_o != $past(wr_slot_o)));

  // R10: with both slots full, a simultaneous release still drains one slot
  p_full_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !slot_free_o) |=> (slot_free_o && !doorbell_o));

endmodule

// File: tb/test_txslot_handoff.sv
module test_txslot_handoff;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       commit_i = 1'b0;
  logic       release_i = 1'b0;
  logic [7:0] status_o;
  logic [3:0] in_count_o;
  logic       slot_free_o, pkt_ready_o, wr_slot_o, rd_slot_o;
  logic       doorbell_o, ovf_err_o, unf_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state derived from the requirements
  int  m_in, m_out;
  bit  m_bell, m_ovf, m_unf;

  always #4 clk = ~clk;

  txslot_handoff i_txslot_handoff (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .release_i(release_i),
    .status_o(status_o), .in_count_o(in_count_o), .slot_free_o(slot_free_o),
    .pkt_ready_o(pkt_ready_o), .wr_slot_o(wr_slot_o), .rd_slot_o(rd_slot_o),
    .doorbell_o(doorbell_o), .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int occ;
    occ = (m_in - m_out) & 15;
    check(tag, "in_count",  int'(in_count_o),  m_in);
    check(tag, "status",    int'(status_o),    m_out);   // R9: low nibble = out count, rest 0
    check(tag, "slot_free", int'(slot_free_o), (occ < 2) ? 1 : 0);
    check(tag, "pkt_ready", int'(pkt_ready_o), (occ != 0) ? 1 : 0);
    check(tag, "wr_slot",   int'(wr_slot_o),   m_in & 1);
    check(tag, "rd_slot",   int'(rd_slot_o),   m_out & 1);
    check(tag, "doorbell",  int'(doorbell_o),  int'(m_bell));
    check(tag, "ovf_err",   int'(ovf_err_o),   int'(m_ovf));
    check(tag, "unf_err",   int'(unf_err_o),   int'(m_unf));
  endtask

  // Drive one cycle of strobes at a falling edge; sample at the next falling edge
  task automatic cycle(input bit c, input bit r);
    int occ;
    bit acc_c, acc_r;
    commit_i  = c;
    release_i = r;
    @(posedge clk);
    occ   = (m_in - m_out) & 15;
    acc_c = c && (occ < 2);
    acc_r = r && (occ != 0);
    if (acc_c) m_in  = (m_in + 1) & 15;
    if (acc_r) m_out = (m_out + 1) & 15;
    if (c && !acc_c) m_ovf = 1'b1;
    if (r && !acc_r) m_unf = 1'b1;
    m_bell = acc_c;
    @(negedge clk);
    commit_i  = 1'b0;
    release_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    commit_i = 1'b0;
    release_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_in = 0; m_out = 0; m_bell = 0; m_ovf = 0; m_unf = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    compare("R1");
  endtask

  task automatic t_fill();
    do_reset();
    cycle(1, 0); compare("R3");   // first packet into slot 0, bell follows
    cycle(0, 0); compare("R5");   // bell gone after one cycle
    cycle(1, 0); compare("R6");   // second packet into slot 1, slot index back to 0
    check("R2", "slot_free_when_full", int'(slot_free_o), 0);
  endtask

  task automatic t_overflow();
    cycle(1, 0); compare("R4");   // rejected: no step, no bell, flag set
    cycle(0, 0); compare("R4");   // flag stays
  endtask

  task automatic t_drain();
    cycle(0, 1); compare("R7");
    cycle(0, 1); compare("R7");
    check("R9", "status_after_two", int'(status_o), 2);
    cycle(0, 1); compare("R8");   // release with empty store
    cycle(0, 0); compare("R8");
  endtask

  task automatic t_simul();
    do_reset();
    cycle(1, 0); compare("R10");
    cycle(1, 1); compare("R10");  // one occupied: both honoured
    cycle(1, 0); compare("R10");  // now full
    cycle(1, 1); compare("R10");  // full: release wins, commit rejected
    check("R10", "ovf_on_full_pair", int'(ovf_err_o), 1);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      cycle(1, 0); compare("R11");
      cycle(1, 0); compare("R11");
      cycle(0, 1); compare("R11");
      cycle(0, 1); compare("R11");
    end
    compare("R9");
  endtask

  initial begin
    t_reset();
    t_fill();
    t_overflow();
    t_drain();
    t_simul();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule